// File: doc/BRIEF.md
# Boundary Test Pattern Engine

This block sits behind an 18-bit ring of boundary cells. It carries out the self-test actions that run while the part is in test mode. In that mode the functional path no longer reaches the pins. The registered output vector shows a pattern register instead, and each test-clock update strobe advances that register by one step of the selected action. The four actions are:

- compressing the sampled inputs into a signature;
- stepping a pseudorandom generator;
- inverting the output cells while capturing the inputs;
- counting upward in binary.

An instruction controller outside the block picks the action through `mode`. The pattern register doubles as an 18-bit serial chain, so a seed can be shifted in and a signature shifted out, least significant bit first. The TAP state machine and the functional transceiver are not part of this block.

Top module: `bpat_engine`

## Requirements
- R1: A synchronous active-high `rst` clears the pattern register, `out_vec` and `sample_vec` to zero.
- R2: `out_vec` is registered. One cycle after any edge at which `test_mode` is 1, it equals the pattern register. When `test_mode` is 0 it equals `func_in` one cycle later.
- R3: Mode 2'b00 is signature compression. On an accepted strobe with pattern p, the next value is {p[16:0], p[17]^p[10]} XOR `in_vec`. The feedback polynomial is x^18+x^11+1.
- R4: Mode 2'b01 is pseudorandom generation with the same polynomial. A nonzero p becomes {p[16:0], p[17]^p[10]}. A zero p becomes 18'h00001.
- R5: Mode 2'b10 is sample/toggle. An accepted strobe inverts every bit of the pattern register and loads `in_vec` into `sample_vec`. In all other modes `sample_vec` holds its value.
- R6: Mode 2'b11 is binary count. An accepted strobe adds one to the pattern register, and 18'h3FFFF wraps to 18'h00000.
- R7: A strobe is accepted only when `update` is 1, `test_mode` is 1 and `shift_en` is 0. In every other cycle the pattern register holds its value.
- R8: While `shift_en` is 1, the pattern register shifts one place toward bit 0 each cycle, and `scan_in` enters bit 17. `scan_out` always shows bit 0. Eighteen shifts therefore load a word sent LSB first. Shifting takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects the pattern register for the outputs and enables strobes |
| mode | input | 2 | Action select from the instruction controller |
| update | input | 1 | Update strobe, one cycle per step |
| shift_en | input | 1 | Serial shift enable |
| scan_in | input | 1 | Serial data into bit 17 |
| scan_out | output | 1 | Serial data from bit 0 |
| in_vec | input | 18 | Values sampled at the input cells |
| func_in | input | 18 | Functional data shown when not in test mode |
| out_vec | output | 18 | Registered output-cell vector |
| sample_vec | output | 18 | Inputs captured by the sample/toggle action |

## Verification
The assertions rely on two assumptions about the inputs. First, `mode` is stable in any cycle where a strobe is accepted. Second, reset is held for at least one clock before checking starts. The checks that compare against the previous pattern apply only to strobes that meet the R7 acceptance rule. The stimulus changes every input only at the falling clock edge, and it changes `mode` only while `update` is 0. It also drives `update` together with `shift_en` deliberately, once, to exercise the R8 priority rule.

// File: rtl/bpat_pkg.sv
package bpat_pkg;
  typedef enum logic [1:0] {
    PM_SIG    = 2'b00,
    PM_RAND   = 2'b01,
    PM_TOGGLE = 2'b10,
    PM_COUNT  = 2'b11
  } pmode_e;
endpackage

// File: rtl/bpat_step.sv
module bpat_step #(
  parameter int W      = 18,
  parameter int TAP_HI = 17,
  parameter int TAP_LO = 10
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] nxt
);
  import bpat_pkg::*;

  logic          fb;
  logic [W-1:0]  lfsr_nxt;

  assign fb       = cur[TAP_HI] ^ cur[TAP_LO];
  assign lfsr_nxt = {cur[W-2:0], fb};

  always_comb begin
    unique case (pmode_e'(mode))
      PM_SIG:    nxt = lfsr_nxt ^ in_vec;
      PM_RAND:   nxt = (cur == '0) ? W'(1) : lfsr_nxt;
      PM_TOGGLE: nxt = ~cur;
      PM_COUNT:  nxt = cur + W'(1);
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/bpat_chain.sv
module bpat_chain #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         step_en,
  input  logic         scan_in,
  input  logic [W-1:0] step_val,
  output logic [W-1:0] pat_q
);
  always_ff @(posedge clk) begin
    if (rst)           pat_q <= '0;
    else if (shift_en) pat_q <= {scan_in, pat_q[W-1:1]};
    else if (step_en)  pat_q <= step_val;
  end
endmodule

// File: rtl/bpat_outreg.sv
module bpat_outreg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_test,
  input  logic [W-1:0] test_val,
  input  logic [W-1:0] func_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sel_test ? test_val : func_val;
  end
endmodule

// File: rtl/bpat_engine.sv
module bpat_engine #(
  parameter int W      = 18,
  parameter int TAP_HI = 17,
  parameter int TAP_LO = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic [1:0]   mode,
  input  logic         update,
  input  logic         shift_en,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [W-1:0] in_vec,
  input  logic [W-1:0] func_in,
  output logic [W-1:0] out_vec,
  output logic [W-1:0] sample_vec
);
  import bpat_pkg::*;

  logic [W-1:0] pat_q;
  logic [W-1:0] step_val;
  logic         step_en;

  assign step_en  = update & test_mode & ~shift_en;
  assign scan_out = pat_q[0];

  bpat_step #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
    .mode   (mode),
    .cur    (pat_q),
    .in_vec (in_vec),
    .nxt    (step_val)
  );

  bpat_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .step_en  (step_en),
    .scan_in  (scan_in),
    .step_val (step_val),
    .pat_q    (pat_q)
  );

  bpat_outreg #(.W(W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .sel_test (test_mode),
    .test_val (pat_q),
    .func_val (func_in),
    .q        (out_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)
      sample_vec <= '0;
    else if (step_en && pmode_e'(mode) == PM_TOGGLE)
      sample_vec <= in_vec;
  end
endmodule

// File: rtl/bpat_checker.sv
module bpat_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         test_mode,
  input logic [1:0]   mode,
  input logic         update,
  input logic         shift_en,
  input logic         scan_in,
  input logic         scan_out,
  input logic [W-1:0] in_vec,
  input logic [W-1:0] pat_q,
  input logic [W-1:0] out_vec,
  input logic [W-1:0] sample_vec
);
  logic acc;
  assign acc = update & test_mode & ~shift_en;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_vec == '0 && sample_vec == '0 && pat_q == '0));

  a_r2_out_follows: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> out_vec == $past(pat_q));

  a_r4_rand_nonzero: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b01) |=> pat_q != '0);

  a_r5_toggle_inv: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b10) |=> (pat_q == ~$past(pat_q) && sample_vec == $past(in_vec)));

  a_r5_sample_hold: assert property (@(posedge clk) disable iff (rst)
    !(acc && mode == 2'b10) |=> $stable(sample_vec));

  a_r6_count_inc: assert property (@(posedge clk) disable iff (rst)
    (acc && mode == 2'b11) |=> pat_q == W'($past(pat_q) + W'(1)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!acc && !shift_en) |=> $stable(pat_q));

  a_r8_shift: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (pat_q[W-1] == $past(scan_in) && scan_out == $past(pat_q[1])));
endmodule

bind bpat_engine bpat_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .test_mode  (test_mode),
  .mode       (mode),
  .update     (update),
  .shift_en   (shift_en),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .in_vec     (in_vec),
  .pat_q      (pat_q),
  .out_vec    (out_vec),
  .sample_vec (sample_vec)
);

// File: tb/bpat_engine_tb.sv
`timescale 1ns/1ps
module bpat_engine_tb;
  localparam int W = 18;

  logic         clk = 0;
  logic         rst = 1;
  logic         test_mode = 0;
  logic [1:0]   mode = 2'b00;
  logic         update = 0;
  logic         shift_en = 0;
  logic         scan_in = 0;
  logic         scan_out;
  logic [W-1:0] in_vec = '0;
  logic [W-1:0] func_in = '0;
  logic [W-1:0] out_vec;
  logic [W-1:0] sample_vec;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_p;

  always #4 clk = ~clk;

  bpat_engine #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .mode(mode),
    .update(update), .shift_en(shift_en), .scan_in(scan_in),
    .scan_out(scan_out), .in_vec(in_vec), .func_in(func_in),
    .out_vec(out_vec), .sample_vec(sample_vec)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lfsr(logic [W-1:0] p);
    return {p[W-2:0], p[17] ^ p[10]};
  endfunction

  task automatic strobe(logic [1:0] m);
    @(negedge clk);
    mode = m; update = 1;
    @(negedge clk);
    update = 0;
    @(negedge clk);
  endtask

  task automatic shift_word(logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      shift_en = 1; scan_in = w[i];
    end
    @(negedge clk);
    shift_en = 0;
    @(negedge clk);
  endtask

  task automatic read_word(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      w[i] = scan_out;
      shift_en = 1; scan_in = scan_out;
    end
    @(negedge clk);
    shift_en = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_vec", out_vec, '0);
    check("R1 sample_vec", sample_vec, '0);
    check("R1 scan_out", {17'b0, scan_out}, '0);
  endtask

  task automatic t_shift();
    logic [W-1:0] rb;
    test_mode = 1;
    exp_p = 18'h2A5C3;
    shift_word(exp_p);
    check("R8 load via shift", out_vec, exp_p);
    read_word(rb);
    check("R8 readback LSB first", rb, exp_p);
    check("R8 recirculated", out_vec, exp_p);
  endtask

  task automatic t_psa();
    logic [W-1:0] vecs [3] = '{18'h00001, 18'h3C0F0, 18'h15555};
    exp_p = 18'h20400;
    shift_word(exp_p);
    foreach (vecs[k]) begin
      in_vec = vecs[k];
      strobe(2'b00);
      exp_p = lfsr(exp_p) ^ vecs[k];
      check("R3 signature", out_vec, exp_p);
    end
  endtask

  task automatic t_prpg();
    exp_p = '0;
    shift_word(exp_p);
    strobe(2'b01);
    exp_p = 18'h00001;
    check("R4 zero seed forced", out_vec, exp_p);
    for (int k = 0; k < 4; k++) begin
      strobe(2'b01);
      exp_p = lfsr(exp_p);
      check("R4 pseudorandom step", out_vec, exp_p);
    end
    exp_p = 18'h20400;
    shift_word(exp_p);
    strobe(2'b01);
    exp_p = lfsr(exp_p);
    check("R4 feedback taps", out_vec, exp_p);
  endtask

  task automatic t_toggle();
    exp_p = 18'h0F0F3;
    shift_word(exp_p);
    in_vec = 18'h2B1D4;
    strobe(2'b10);
    exp_p = ~exp_p;
    check("R5 toggle outputs", out_vec, exp_p);
    check("R5 sample inputs", sample_vec, 18'h2B1D4);
    in_vec = 18'h11111;
    strobe(2'b11);
    check("R5 sample holds in other mode", sample_vec, 18'h2B1D4);
  endtask

  task automatic t_count();
    exp_p = 18'h3FFFE;
    shift_word(exp_p);
    strobe(2'b11);
    check("R6 count increment", out_vec, 18'h3FFFF);
    strobe(2'b11);
    check("R6 count wrap", out_vec, 18'h00000);
    strobe(2'b11);
    check("R6 count after wrap", out_vec, 18'h00001);
  endtask

  task automatic t_ignore();
    exp_p = 18'h12345;
    shift_word(exp_p);
    test_mode = 0;
    func_in = 18'h0ABCD;
    strobe(2'b11);
    check("R2 functional path", out_vec, 18'h0ABCD);
    test_mode = 1;
    @(negedge clk);
    check("R7 strobe ignored outside test", out_vec, exp_p);
    repeat (3) @(negedge clk);
    check("R7 holds without strobe", out_vec, exp_p);
  endtask

  task automatic t_priority();
    exp_p = 18'h00006;
    shift_word(exp_p);
    @(negedge clk);
    mode = 2'b11; update = 1; shift_en = 1; scan_in = 1;
    @(negedge clk);
    update = 0; shift_en = 0; scan_in = 0;
    @(negedge clk);
    check("R8 shift over strobe", out_vec, {1'b1, exp_p[W-1:1]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_shift();
    t_psa();
    t_prpg();
    t_toggle();
    t_count();
    t_ignore();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule